// File: doc/BRIEF.md
# Configurable Sum-of-Products Macrocell Array

This block models a programmable AND-OR logic array feeding ten output macrocells. Twenty-two signals enter the array: one pin that serves as both the register clock and an ordinary input, eleven dedicated inputs, and ten feedback signals, one from each macrocell. Every product term can use the true form, the complement form, or neither form of each array signal. Each macrocell ORs its own group of product terms. The result can be used directly or captured in a register. It then passes through a polarity stage and reaches a pin whose output enable comes from a product term owned by that macrocell.

Two extra product terms act on every macrocell register at once. One clears the registers asynchronously. The other sets them at the next clock edge. The configuration is a static vector on input ports and is never reprogrammed while the block runs. It consists of the AND-array connection bits, one register/combinatorial select bit per macrocell, and one polarity bit per macrocell.

Each pad is modelled as three separate signals: the level seen on the pad (`pin_i`), the driven value (`pin_o`) and the drive enable (`pin_oe`). The surrounding pad logic is expected to present the driven value on `pin_i` whenever `pin_oe` is high.

Top module: `sop_array`

## Requirements
- R1: The array signal index is k = 0 for `clk`, k = 1..11 for `ded_i[k-1]`, and k = 12..21 for the feedback of macrocell k-12. Column 2k carries the true form of signal k and column 2k+1 carries its complement. Fuse bit `t*44 + c` set to 1 connects column c to product term t. A product term is the AND of its connected columns.
- R2: A product term with no connected column evaluates to 1. A product term with both columns of one signal connected evaluates to 0.
- R3: Macrocell i owns a block of terms starting at the sum of (1 + count(j)) for all j < i, where count(i) = 8 + 2*(i/2). This gives counts of 8, 8, 10, 10, 12, 12, 14, 14, 16, 16. The first term of each block is the output-enable term and the rest are sum terms. Term 130 is the shared asynchronous clear and term 131 is the shared synchronous preset.
- R4: With `cfg_reg[i]` = 0, `pin_o[i]` follows the OR of the macrocell's sum terms combinationally.
- R5: With `cfg_reg[i]` = 1, the register loads the OR of the sum terms on each rising `clk` edge, and `pin_o[i]` shows the register.
- R6: `cfg_inv[i]` = 1 inverts `pin_o[i]`. The inversion comes after the register, so the register and its feedback hold the uninverted sum.
- R7: `pin_oe[i]` equals the macrocell's enable term. A pin whose enable is off serves as an input.
- R8: The feedback of a registered macrocell is its register. The feedback of a combinatorial macrocell is `pin_i[i]`.
- R9: When the preset term is 1 at a rising edge, every register becomes 1.
- R10: The clear term forces every register to 0 at once, with no clock edge needed, and it overrides the preset.
- R11: `rst` high at a rising edge clears every register. This is the power-up clear, and it overrides the preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, also array signal 0 |
| rst | input | 1 | Synchronous active-high power-up clear |
| ded_i | input | 11 | Dedicated array inputs |
| pin_i | input | 10 | Level present on each I/O pad |
| pin_o | output | 10 | Value each macrocell drives toward its pad |
| pin_oe | output | 10 | Pad drive enable from each enable term |
| cfg_and | input | 5808 | AND-array connection bits, 44 per product term |
| cfg_reg | input | 10 | 1 = registered macrocell, 0 = combinatorial |
| cfg_inv | input | 10 | 1 = inverted output |

## Verification
A two-input decoder map is stepped through all four select codes. This separates single-literal, multi-literal and multi-term sums, inverted from plain polarity, and always-true terms from conflicting terms. It also places a literal in the last sum term of a 16-term macrocell, which would show any error in the block offsets. A disabled pad whose external level is toggled shows that combinatorial feedback comes from the pad rather than from the output. A 4-bit counter map with an enable, one inverted bit, a wrap past 15, preset and clear (alone and together) and a power-up clear shows that registered feedback carries the uninverted register, and confirms the stated priority order.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Sum terms owned by macrocell idx: counts grow in pairs.
  function automatic int pt_count(input int idx, input int base, input int step);
    return base + step * (idx / 2);
  endfunction

  // First term (the enable term) of macrocell idx's block.
  function automatic int pt_offset(input int idx, input int base, input int step);
    int acc;
    acc = 0;
    for (int j = 0; j < idx; j++) acc += 1 + pt_count(j, base, step);
    return acc;
  endfunction

  // All macrocell blocks plus the shared clear and preset terms.
  function automatic int pt_total(input int n_mc, input int base, input int step);
    return pt_offset(n_mc, base, step) + 2;
  endfunction

endpackage

// File: rtl/sop_term.sv
module sop_term #(
  parameter int N_COL = 44
) (
  input  logic [N_COL-1:0] cols,
  input  logic [N_COL-1:0] fuse,
  output logic             pt
);

  localparam int N_SIG = N_COL / 2;

  // A column only takes part when its fuse bit is set.
  assign pt = &(cols | ~fuse);

  logic conflict;
  always_comb begin
    conflict = 1'b0;
    for (int k = 0; k < N_SIG; k++)
      if (fuse[2*k] && fuse[2*k+1]) conflict = 1'b1;
  end

  always_comb begin
    if (conflict) AST_CONFLICT_ZERO: assert (!pt);   // R2
    if (fuse == '0) AST_EMPTY_ONE: assert (pt);      // R2
  end

endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell #(
  parameter int N_PT = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ar,
  input  logic            sp,
  input  logic            is_reg,
  input  logic            invert,
  input  logic            oe_pt,
  input  logic [N_PT-1:0] sum_pt,
  input  logic            pad_i,
  output logic            pad_o,
  output logic            pad_oe,
  output logic            fb
);

  logic sum;
  logic q;
  logic pre_pol;

  assign sum = |sum_pt;

  // Priority: async clear, power-up clear, preset, normal load.
  always_ff @(posedge clk or posedge ar) begin
    if (ar)       q <= 1'b0;
    else if (rst) q <= 1'b0;
    else if (sp)  q <= 1'b1;
    else          q <= sum;
  end

  assign pre_pol = is_reg ? q : sum;
  assign pad_o   = pre_pol ^ invert;
  assign pad_oe  = oe_pt;
  assign fb      = is_reg ? q : pad_i;

  AST_PWRUP_CLEAR: assert property (@(posedge clk) disable iff (ar)
    rst |=> !q);                                                   // R11
  AST_AR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ar |-> !q);                                                    // R10
  AST_PRESET_SETS: assert property (@(posedge clk) disable iff (rst || ar)
    sp |=> q);                                                     // R9
  AST_REG_LOADS: assert property (@(posedge clk) disable iff (rst || ar)
    !sp |=> (q == $past(sum)));                                    // R5

endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_pkg::*;
#(
  parameter  int N_DED   = 11,
  parameter  int N_MC    = 10,
  parameter  int PT_BASE = 8,
  parameter  int PT_STEP = 2,
  localparam int N_SIG   = 1 + N_DED + N_MC,
  localparam int N_COL   = 2 * N_SIG,
  localparam int N_PT    = pt_total(N_MC, PT_BASE, PT_STEP),
  localparam int FUSE_W  = N_PT * N_COL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_DED-1:0]  ded_i,
  input  logic [N_MC-1:0]   pin_i,
  output logic [N_MC-1:0]   pin_o,
  output logic [N_MC-1:0]   pin_oe,
  input  logic [FUSE_W-1:0] cfg_and,
  input  logic [N_MC-1:0]   cfg_reg,
  input  logic [N_MC-1:0]   cfg_inv
);

  localparam int AR_IDX = N_PT - 2;
  localparam int SP_IDX = N_PT - 1;

  logic [N_SIG-1:0] sig;
  logic [N_COL-1:0] cols;
  logic [N_PT-1:0]  pt;
  logic [N_MC-1:0]  fb;
  logic             ar;
  logic             sp;

  assign sig = {fb, ded_i, clk};

  for (genvar k = 0; k < N_SIG; k++) begin : g_col
    assign cols[2*k]   = sig[k];
    assign cols[2*k+1] = ~sig[k];
  end

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    sop_term #(.N_COL(N_COL)) u_term (
      .cols (cols),
      .fuse (cfg_and[t*N_COL +: N_COL]),
      .pt   (pt[t])
    );
  end

  assign ar = pt[AR_IDX];
  assign sp = pt[SP_IDX];

  for (genvar i = 0; i < N_MC; i++) begin : g_mc
    localparam int OFF = pt_offset(i, PT_BASE, PT_STEP);
    localparam int CNT = pt_count(i, PT_BASE, PT_STEP);
    sop_macrocell #(.N_PT(CNT)) u_mc (
      .clk    (clk),
      .rst    (rst),
      .ar     (ar),
      .sp     (sp),
      .is_reg (cfg_reg[i]),
      .invert (cfg_inv[i]),
      .oe_pt  (pt[OFF]),
      .sum_pt (pt[OFF+1 +: CNT]),
      .pad_i  (pin_i[i]),
      .pad_o  (pin_o[i]),
      .pad_oe (pin_oe[i]),
      .fb     (fb[i])
    );
  end

endmodule

// File: tb/tb_sop_array.sv
module tb_sop_array;

  localparam int N_COL = 44;
  localparam int N_PT  = 132;
  localparam int FW    = N_PT * N_COL;
  localparam int AR_T  = 130;
  localparam int SP_T  = 131;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [10:0]   ded = '0;
  logic [9:0]    pin_i = '0;
  logic [9:0]    cfg_reg = '0;
  logic [9:0]    cfg_inv = '0;
  logic [FW-1:0] fm;
  logic [9:0]    pin_o;
  logic [9:0]    pin_oe;

  int n_chk = 0;
  int n_bad = 0;
  int cnt   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  sop_array dut (
    .clk(clk), .rst(rst), .ded_i(ded), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe(pin_oe),
    .cfg_and(fm), .cfg_reg(cfg_reg), .cfg_inv(cfg_inv)
  );

  function automatic int off(input int i);
    int s;
    s = 0;
    for (int j = 0; j < i; j++) s += 9 + 2 * (j / 2);
    return s;
  endfunction

  function automatic int sm(input int i, input int n);
    return off(i) + 1 + n;
  endfunction

  task automatic tclr(input int t);
    for (int c = 0; c < N_COL; c++) fm[t*N_COL + c] = 1'b0;
  endtask

  task automatic tlit(input int t, input int k, input int neg);
    fm[t*N_COL + 2*k + neg] = 1'b1;
  endtask

  // Every term forced to 0 by connecting both forms of signal 1.
  task automatic zero_all();
    for (int t = 0; t < N_PT; t++) begin
      tclr(t);
      tlit(t, 1, 0);
      tlit(t, 1, 1);
    end
  endtask

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic tick(input logic en, input string req);
    @(negedge clk);
    ded[2] = en;
    @(posedge clk);
    #1;
    if (en) cnt = (cnt + 1) % 16;
    chk(req, {6'd0, pin_o[3:0]}, {6'd0, 4'(cnt) ^ 4'b0010});
  endtask

  // {select, expected pin_o} for the decoder map
  localparam logic [11:0] DEC_TBL [4] = '{
    {2'd0, 10'b0000101001},
    {2'd1, 10'b0100111010},
    {2'd2, 10'b0000111100},
    {2'd3, 10'b0100110000}
  };

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    zero_all();
    cfg_reg = '1;
    repeat (2) @(posedge clk);
    #1;
    chk("R11 reset", pin_o, 10'd0);
    chk("R7 reset enables", pin_oe, 10'd0);
    @(negedge clk);
    rst = 1'b0;

    // ---------------- decoder map (combinatorial) ----------------
    zero_all();
    for (int i = 0; i < 9; i++) tclr(off(i));
    tclr(sm(0,0)); tlit(sm(0,0), 1, 1); tlit(sm(0,0), 2, 1);
    tclr(sm(1,0)); tlit(sm(1,0), 1, 0); tlit(sm(1,0), 2, 1);
    tclr(sm(2,0)); tlit(sm(2,0), 1, 1); tlit(sm(2,0), 2, 0);
    tclr(sm(3,0)); tlit(sm(3,0), 1, 0); tlit(sm(3,0), 2, 0);
    tclr(sm(4,0)); tlit(sm(4,0), 1, 0);
    tclr(sm(4,1)); tlit(sm(4,1), 2, 0);
    tclr(sm(5,0));
    tclr(sm(6,0)); tlit(sm(6,0), 1, 0); tlit(sm(6,0), 1, 1);
    tclr(sm(7,0)); tlit(sm(7,0), 21, 0);
    tclr(sm(8,15)); tlit(sm(8,15), 1, 0);
    cfg_reg = '0;
    cfg_inv = 10'b0000001000;
    pin_i   = '0;

    foreach (DEC_TBL[v]) begin
      @(negedge clk);
      ded[1:0] = DEC_TBL[v][11:10];
      #2;
      chk("R1 R2 R3 R4 R6 decoder", pin_o, DEC_TBL[v][9:0]);
    end
    chk("R7 enables", pin_oe, 10'b0111111111);

    @(negedge clk);
    ded = '0;
    pin_i[9] = 1'b1;
    #2;
    chk("R8 pad feedback high", pin_o, 10'b0010101001);
    pin_i[9] = 1'b0;
    #2;
    chk("R8 pad feedback low", pin_o, 10'b0000101001);

    // ---------------- 4-bit counter map (registered) ----------------
    zero_all();
    for (int i = 0; i < 4; i++) tclr(off(i));
    tclr(sm(0,0)); tlit(sm(0,0), 12, 0); tlit(sm(0,0), 3, 1);
    tclr(sm(0,1)); tlit(sm(0,1), 12, 1); tlit(sm(0,1), 3, 0);
    for (int b = 1; b < 4; b++) begin
      tclr(sm(b,0)); tlit(sm(b,0), 12 + b, 0); tlit(sm(b,0), 3, 1);
      for (int l = 0; l < b; l++) begin
        tclr(sm(b,1+l)); tlit(sm(b,1+l), 12 + b, 0); tlit(sm(b,1+l), 12 + l, 1);
      end
      tclr(sm(b,1+b)); tlit(sm(b,1+b), 12 + b, 1); tlit(sm(b,1+b), 3, 0);
      for (int l = 0; l < b; l++) tlit(sm(b,1+b), 12 + l, 0);
    end
    tclr(SP_T); tlit(SP_T, 4, 0);
    tclr(AR_T); tlit(AR_T, 5, 0);
    cfg_reg = 10'b0000001111;
    cfg_inv = 10'b0000000010;

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cnt = 0;
    chk("R11 counter clear", {6'd0, pin_o[3:0]}, 10'b0000000010);
    chk("R7 counter enables", {6'd0, pin_oe[3:0]}, 10'b0000001111);

    for (int n = 0; n < 5; n++) tick(1'b1, "R5 R8 count");
    for (int n = 0; n < 2; n++) tick(1'b0, "R5 hold");
    chk("R6 stored uninverted", {9'd0, pin_o[1]}, {9'd0, ~cnt[1]});
    for (int n = 0; n < 12; n++) tick(1'b1, "R5 wrap");

    @(negedge clk);
    ded[3] = 1'b1;
    @(posedge clk);
    #1;
    cnt = 15;
    chk("R9 preset", {6'd0, pin_o[3:0]}, {6'd0, 4'b1101});
    @(negedge clk);
    ded[3] = 1'b0;
    ded[2] = 1'b0;

    @(negedge clk);
    ded[4] = 1'b1;
    #1;
    cnt = 0;
    chk("R10 immediate clear", {6'd0, pin_o[3:0]}, 10'b0000000010);
    ded[3] = 1'b1;
    @(posedge clk);
    #1;
    chk("R10 clear over preset", {6'd0, pin_o[3:0]}, 10'b0000000010);
    @(negedge clk);
    ded = '0;
    tick(1'b1, "R8 feedback after clear");
    tick(1'b1, "R5 count");

    @(negedge clk);
    rst = 1'b1;
    ded[3] = 1'b1;
    @(posedge clk);
    #1;
    cnt = 0;
    chk("R11 clear over preset", {6'd0, pin_o[3:0]}, 10'b0000000010);
    @(negedge clk);
    rst = 1'b0;
    ded = '0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule